// File: doc/BRIEF.md
# Single-Precision Compare Condition-Code Unit

This block takes two 32-bit IEEE 754 single-precision operands and ranks them. It writes the two-bit outcome into one of four condition-code fields of a status word. A start strobe launches one compare. The result is registered, so it appears on the outputs after the clock edge that samples the strobe.

A NaN in either operand makes the compare unordered. If the invalid-operation trap is enabled, the block leaves the condition code unchanged. It sets the current-invalid flag, loads the IEEE-exception trap type and raises a one-cycle trap request. If the trap is masked, it writes the unordered code and sets the sticky accrued-invalid flag. A select input picks the signaling variant or the quiet variant. The signaling variant tests for a NaN directly. The quiet variant tests for an unordered outcome. For single-precision operands both tests catch the same operands.

The four fields sit at status bits [1:0], [23:22], [25:24] and [27:26]. The other bits of the status word read zero. A host decodes the fields by these positions.

Top module: `fcmp_cc_unit`

## Requirements
- R1: Code values are equal = 2'b00, A below B = 2'b01, A above B = 2'b10 and unordered = 2'b11. Ordering follows sign and magnitude, so any negative operand is below any positive one and +0 equals -0.
- R2: `field_sel_i` values 0, 1, 2 and 3 select status bits [1:0], [23:22], [25:24] and [27:26]. Every other status bit stays 0.
- R3: A compare changes only the selected field. The other three fields keep their values.
- R4: An unordered compare with the trap disabled writes 2'b11 into the selected field and sets `acc_inv_o`. `acc_inv_o` then stays set until reset.
- R5: A compare with a NaN operand and the trap enabled does not write the field. It raises `trap_o` and sets `cur_inv_o`. It loads `trap_type_o` with 3'b001. This holds in both the quiet and the signaling variant.
- R6: A compare that does not trap clears `trap_type_o` to 3'b000.
- R7: A compare started in the cycle where `start_i` is high takes effect on that clock edge. `trap_o` is high for exactly that one cycle.
- R8: While `start_i` is low, the operand, select and enable inputs have no effect on any output.
- R9: Reset clears the status word, both invalid flags, the trap type and the trap request.
- R10: `cur_inv_o` stays set until reset once a trap has set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch one compare |
| signaling_i | input | 1 | 1 = signaling variant, 0 = quiet variant |
| field_sel_i | input | 2 | Selects the target condition-code field |
| inv_trap_en_i | input | 1 | Invalid-operation trap enable |
| op_a_i | input | 32 | Operand A |
| op_b_i | input | 32 | Operand B |
| status_o | output | 32 | Status word holding the four condition-code fields |
| acc_inv_o | output | 1 | Accrued invalid flag |
| cur_inv_o | output | 1 | Current invalid flag |
| trap_type_o | output | 3 | Trap type, 3'b001 = IEEE exception |
| trap_o | output | 1 | Trap request pulse |

## Verification
The bench compares +0 with -0 and checks that the result is equal. It pairs negative operands, because a design that compares magnitudes without regard to sign would reverse that order. It uses denormals and infinities on the edges of the ordering. It drives quiet and signaling NaNs with the trap both masked and enabled. A trapping compare must leave the field untouched. A non-trapping compare that follows must clear the trap type. Reusing a trapping field or forgetting to clear the trap type would leave stale state. The bench visits every field position and keeps track of the other fields. A wrong offset, or a write that spills into a neighbouring field, shows up as a corrupted status word. Stimulus applied while `start_i` is low, and a mid-run reset, cover the hold and clear behaviour.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef enum logic [1:0] {
    CC_EQ = 2'b00,
    CC_LT = 2'b01,
    CC_GT = 2'b10,
    CC_UN = 2'b11
  } cc_e;

  localparam logic [2:0] TT_NONE = 3'b000;
  localparam logic [2:0] TT_IEEE = 3'b001;

  // field 0 at bit 0, others packed from bit 22 upward
  function automatic int unsigned field_off(input int unsigned idx);
    return (idx == 0) ? 0 : 20 + 2 * idx;
  endfunction
endpackage

// File: rtl/fcmp_nan_detect.sv
module fcmp_nan_detect #(
  parameter int unsigned W     = 32,
  parameter int unsigned EXP_W = 8
) (
  input  logic [W-1:0] op_i,
  output logic         nan_o
);
  localparam int unsigned MAN_W = W - 1 - EXP_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  assign exp_f = op_i[W-2 -: EXP_W];
  assign man_f = op_i[MAN_W-1:0];
  assign nan_o = (&exp_f) && (|man_f);
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output fcmp_pkg::cc_e   rel_o
);
  import fcmp_pkg::*;

  logic         sa, sb;
  logic [W-2:0] ma, mb;
  logic         zeros, mag_lt;

  assign sa     = a_i[W-1];
  assign sb     = b_i[W-1];
  assign ma     = a_i[W-2:0];
  assign mb     = b_i[W-2:0];
  assign zeros  = (ma == '0) && (mb == '0);
  assign mag_lt = ma < mb;

  always_comb begin
    if (zeros || (a_i == b_i))  rel_o = CC_EQ;
    else if (sa != sb)          rel_o = sa ? CC_LT : CC_GT;
    else if (!sa)               rel_o = mag_lt ? CC_LT : CC_GT;
    else                        rel_o = mag_lt ? CC_GT : CC_LT;
  end
endmodule

// File: rtl/fcmp_cc_reg.sv
module fcmp_cc_reg #(
  parameter int unsigned CC_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [CC_W-1:0] cc_i,
  output logic [CC_W-1:0] cc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cc_o <= '0;
    else if (we_i) cc_o <= cc_i;
  end

  // R3
  field_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cc_o));
endmodule

// File: rtl/fcmp_cc_unit.sv
module fcmp_cc_unit #(
  parameter int unsigned W      = 32,
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned NFIELD = 4,
  parameter int unsigned SEL_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             signaling_i,
  input  logic [SEL_W-1:0] field_sel_i,
  input  logic             inv_trap_en_i,
  input  logic [W-1:0]     op_a_i,
  input  logic [W-1:0]     op_b_i,
  output logic [31:0]      status_o,
  output logic             acc_inv_o,
  output logic             cur_inv_o,
  output logic [2:0]       trap_type_o,
  output logic             trap_o
);
  import fcmp_pkg::*;

  localparam int unsigned CC_W = 2;

  logic  nan_a, nan_b, any_nan;
  cc_e   rel;
  logic  unord, sig_trap, quiet_trap, take_trap;
  logic [CC_W-1:0] cc_new;
  logic [CC_W-1:0] cc_q [NFIELD];
  logic [NFIELD-1:0] we;

  fcmp_nan_detect #(.W(W), .EXP_W(EXP_W)) i_nan_a (.op_i(op_a_i), .nan_o(nan_a));
  fcmp_nan_detect #(.W(W), .EXP_W(EXP_W)) i_nan_b (.op_i(op_b_i), .nan_o(nan_b));
  fcmp_order      #(.W(W))                i_order (.a_i(op_a_i), .b_i(op_b_i), .rel_o(rel));

  assign any_nan    = nan_a | nan_b;
  assign unord      = any_nan;
  // signaling variant traps on NaN detect, quiet variant on unordered outcome
  assign sig_trap   = signaling_i && any_nan && inv_trap_en_i;
  assign quiet_trap = unord && inv_trap_en_i;
  assign take_trap  = sig_trap || quiet_trap;
  assign cc_new     = unord ? CC_UN : rel;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    assign we[g] = start_i && !take_trap && (field_sel_i == SEL_W'(g));
    fcmp_cc_reg #(.CC_W(CC_W)) i_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (we[g]),
      .cc_i  (cc_new),
      .cc_o  (cc_q[g])
    );
  end

  always_comb begin
    status_o = '0;
    for (int i = 0; i < NFIELD; i++) status_o[field_off(i) +: CC_W] = cc_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o      <= 1'b0;
      trap_type_o <= TT_NONE;
      acc_inv_o   <= 1'b0;
      cur_inv_o   <= 1'b0;
    end else begin
      trap_o <= start_i && take_trap;
      if (start_i) begin
        trap_type_o <= take_trap ? TT_IEEE : TT_NONE;
        if (take_trap)  cur_inv_o <= 1'b1;
        else if (unord) acc_inv_o <= 1'b1;
      end
    end
  end

  // R5
  trap_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (trap_type_o == TT_IEEE) && cur_inv_o);
  // R5
  trap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $stable(status_o));
  // R7
  trap_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (trap_o == $past(take_trap)));
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(status_o) && $stable(acc_inv_o) && $stable(trap_type_o) && !trap_o);
  // R6
  tt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !take_trap |=> trap_type_o == TT_NONE);
  // R4
  acc_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_inv_o |=> acc_inv_o);
  // R10
  cur_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_inv_o |=> cur_inv_o);
  // R2
  spare_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[21:2] == '0 && status_o[31:28] == '0);
endmodule

// File: tb/test_fcmp_cc_unit.sv
`timescale 1ns/1ps
module test_fcmp_cc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sig = 1'b0, ten = 1'b0;
  logic [1:0]  fsel = '0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] status;
  logic        acc_inv, cur_inv, trap;
  logic [2:0]  ttype;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] e_status = '0;
  logic        e_acc = 1'b0, e_cur = 1'b0;
  logic [2:0]  e_tt = '0;

  always #2 clk = ~clk;

  fcmp_cc_unit i_fcmp_cc_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signaling_i(sig),
    .field_sel_i(fsel), .inv_trap_en_i(ten), .op_a_i(a), .op_b_i(b),
    .status_o(status), .acc_inv_o(acc_inv), .cur_inv_o(cur_inv),
    .trap_type_o(ttype), .trap_o(trap)
  );

  typedef struct packed {
    logic [31:0] a; logic [31:0] b; logic sig; logic [1:0] fsel;
    logic ten; logic [1:0] cc; logic trap;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    {32'h3F800000, 32'h40000000, 1'b0, 2'd0, 1'b0, 2'b01, 1'b0}, // 1 < 2
    {32'h40000000, 32'h3F800000, 1'b0, 2'd1, 1'b0, 2'b10, 1'b0}, // 2 > 1
    {32'hBF800000, 32'hC0000000, 1'b0, 2'd2, 1'b0, 2'b10, 1'b0}, // -1 > -2
    {32'hC0000000, 32'h3F800000, 1'b0, 2'd3, 1'b0, 2'b01, 1'b0}, // -2 < 1
    {32'h00000000, 32'h80000000, 1'b1, 2'd0, 1'b0, 2'b00, 1'b0}, // +0 == -0
    {32'h3F800000, 32'h3F800000, 1'b0, 2'd1, 1'b0, 2'b00, 1'b0}, // 1 == 1
    {32'hFF800000, 32'h00000001, 1'b0, 2'd2, 1'b0, 2'b01, 1'b0}, // -inf < denorm
    {32'h7F800000, 32'h40000000, 1'b1, 2'd3, 1'b0, 2'b10, 1'b0}, // +inf > 2
    {32'h7FC00000, 32'h3F800000, 1'b0, 2'd0, 1'b0, 2'b11, 1'b0}, // qNaN masked
    {32'h3F800000, 32'h7F800001, 1'b1, 2'd1, 1'b0, 2'b11, 1'b0}, // sNaN masked
    {32'h7FC00000, 32'h3F800000, 1'b0, 2'd2, 1'b1, 2'b00, 1'b1}, // quiet trap
    {32'h7F800001, 32'h7F800001, 1'b1, 2'd3, 1'b1, 2'b00, 1'b1}, // signaling trap
    {32'h80000000, 32'h00000001, 1'b0, 2'd0, 1'b0, 2'b01, 1'b0}, // -0 < denorm
    {32'h00000001, 32'h00000002, 1'b0, 2'd3, 1'b0, 2'b01, 1'b0},
    {32'h80000001, 32'h80000002, 1'b0, 2'd2, 1'b0, 2'b10, 1'b0},
    {32'hC0000000, 32'hFF800000, 1'b1, 2'd1, 1'b1, 2'b10, 1'b0}, // -2 > -inf, trap on but ordered
    {32'hFFC00000, 32'h00000000, 1'b1, 2'd0, 1'b1, 2'b00, 1'b1}  // neg NaN trap
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(status == e_status, {tag, " status"}, status, e_status);
    chk(acc_inv == e_acc, {tag, " acc_inv"}, {31'd0, acc_inv}, {31'd0, e_acc});
    chk(cur_inv == e_cur, {tag, " cur_inv"}, {31'd0, cur_inv}, {31'd0, e_cur});
    chk(ttype == e_tt, {tag, " trap_type"}, {29'd0, ttype}, {29'd0, e_tt});
  endtask

  function automatic int off(input logic [1:0] s);
    return (s == 2'd0) ? 0 : 20 + 2 * int'(s);
  endfunction

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    a = v.a; b = v.b; sig = v.sig; fsel = v.fsel; ten = v.ten; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (v.trap) begin
      e_cur = 1'b1; e_tt = 3'b001;
    end else begin
      e_tt = 3'b000;
      e_status[off(v.fsel) +: 2] = v.cc;
      if (v.cc == 2'b11) e_acc = 1'b1;
    end
    // R1 R2 R3 R4 R5 R6: outputs after the sampling edge
    check_all("R1/R5 vec");
    chk(trap == v.trap, "R7 trap pulse", {31'd0, trap}, {31'd0, v.trap});
    @(negedge clk);
    chk(trap == 1'b0, "R7 trap one cycle", {31'd0, trap}, 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check_all("R9 reset");
    chk(trap == 1'b0, "R9 trap", {31'd0, trap}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R2 explicit field positions after the loop
    chk(status[1:0] == e_status[1:0] && status[23:22] == e_status[23:22], "R2 fields",
        status, e_status);

    // R8 inputs ignored without start
    @(negedge clk);
    a = 32'h7FC00000; b = 32'h0; ten = 1'b1; sig = 1'b1; fsel = 2'd2;
    repeat (2) @(negedge clk);
    a = 32'hC0000000; b = 32'h40000000; ten = 1'b0; fsel = 2'd0;
    repeat (2) @(negedge clk);
    check_all("R8 idle");
    chk(trap == 1'b0, "R8 no trap", {31'd0, trap}, 32'd0);

    // R10 R4 flags persist after an ordered compare
    run_vec('{a:32'h3F800000, b:32'h40000000, sig:1'b0, fsel:2'd1, ten:1'b0, cc:2'b01, trap:1'b0});
    chk(cur_inv == 1'b1 && acc_inv == 1'b1, "R10 sticky", {30'd0, cur_inv, acc_inv}, 32'd3);

    // R9 mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    e_status = '0; e_acc = 1'b0; e_cur = 1'b0; e_tt = '0;
    @(negedge clk);
    check_all("R9 midrun");
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule